// File: doc/BRIEF.md
# Reorder Buffer with Precise Exceptions

This block is a circular in-order retirement queue for an out-of-order core. The front end writes one instruction per cycle at the tail and gets back the slot index that serves as its tag. Execution units report completion by that tag, with a result value, an exception flag and, for branches, a misprediction flag. The block keeps every result inside the buffer until the instruction at the head has completed. At that point the head retires and the buffer presents its destination, value and kind to the architectural register file or the store port.

Faults are deferred. A fault is only recorded when it is reported, and nothing happens until the faulting entry reaches the head. At that point the faulting entry and every younger entry are dropped in one cycle, and a flush pulse with a cause code is raised, so architectural state always matches a precise boundary. A mispredicted branch that reaches the head retires normally. Its value (the redirect target) appears on the commit port, and everything behind it is dropped with a different cause code. Stores take their address at issue and their data from completion, and they leave through the commit port only.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty: `issueReady` is 1, `commitValid` and `flushPulse` are 0, `flushCause` is 0 and `issueIdx` is 0.
- R2: Entries retire strictly in issue order, at most one per cycle. An entry retires in the cycle after its completion is accepted, but only when it is at the head. A completed entry behind an uncompleted one waits.
- R3: A retiring entry of kind 0 (register write) shows `commitRegWrite`=1, its destination and its completion value on the commit port. A kind 2 (branch) entry shows neither the store flag nor the register-write flag.
- R4: A kind 1 (store) entry does not retire before its completion arrives. It retires with `commitIsStore`=1, `commitRegWrite`=0, the address given at issue on `commitAddr` and the completion value on `commitValue`.
- R5: An exception flag raised at completion has no visible effect until its entry is at the head. In that cycle `flushPulse`=1, `flushCause`=1 and `commitValid`=0. The next cycle the buffer is empty and the next issue receives index 0.
- R6: A completed branch at the head with its mispredict flag set retires with `commitValid`=1 and `flushPulse`=1, `flushCause`=2. Every younger entry is discarded and never retires.
- R7: `issueReady` is 0 when DEPTH entries are held or a flush is being signalled. Issue requests in those cycles are dropped.
- R8: A completion whose index names an empty, flushed or already completed slot changes nothing. A later occupant of that slot still waits for its own completion.
- R9: `issueIdx` gives the slot the next accepted issue takes. It advances by one per accepted issue, modulo DEPTH.
- R10: An instruction issued with `issueExc`=1 counts as completed with an exception and needs no completion writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request |
| issueKind | input | 2 | 0 register write, 1 store, 2 branch |
| issueDest | input | REG_W | Architectural destination register |
| issueExc | input | 1 | Instruction already faulted at issue |
| issueAddr | input | ADDR_W | Store effective address |
| issueReady | output | 1 | Issue accepted this cycle if requested |
| issueIdx | output | IDX_W | Tag the next accepted issue receives |
| cmplValid | input | 1 | Completion writeback |
| cmplIdx | input | IDX_W | Tag of the completing entry |
| cmplValue | input | DATA_W | Result, store data or branch target |
| cmplExc | input | 1 | Execution raised an exception |
| cmplMispred | input | 1 | Branch was mispredicted |
| commitValid | output | 1 | Head entry retires this cycle |
| commitDest | output | REG_W | Destination of the retiring entry |
| commitValue | output | DATA_W | Value of the retiring entry |
| commitAddr | output | ADDR_W | Store address of the retiring entry |
| commitIsStore | output | 1 | Retiring entry is a store |
| commitRegWrite | output | 1 | Retiring entry writes a register |
| flushPulse | output | 1 | All pending entries are discarded this cycle |
| flushCause | output | 2 | 0 none, 1 exception, 2 mispredicted branch |

## Verification
Directed sequences complete entries in reverse age order, which separates in-order retirement from plain completion order. A store is left waiting for its data, which shows whether it can retire on its address alone. An exception is placed on a younger entry, behind an older one that is still running, which shows whether the fault is acted on early or deferred to the head. A wild completion to an empty slot is sent ahead of that slot's later occupant, and a full buffer is hammered with issue requests. A long constrained-random run then mixes kinds, faults, mispredicts and stray tags against a bench queue model, which exposes pointer wrap and same-cycle issue/commit/complete interactions.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_EXC     = 2'd1,
    CAUSE_MISPRED = 2'd2
  } cause_e;

  // write strobes from control to the entry storage
  typedef struct packed {
    logic issueWe;
    logic cmplWe;
  } strobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             issueExc,
  input  logic             cmplValid,
  input  logic [IDX_W-1:0] cmplIdx,
  input  logic             headExc,
  input  logic             headMispred,
  input  logic [1:0]       headKind,
  output logic             issueReady,
  output logic [IDX_W-1:0] tailIdx,
  output logic [IDX_W-1:0] headIdx,
  output strobe_t          stb,
  output logic             commitFire,
  output logic             flushNow,
  output logic [1:0]       flushCause
);
  logic [PTR_W-1:0] headPtr, tailPtr;
  logic [DEPTH-1:0] validQ, doneQ, validNext, doneNext;
  logic full, headReady, takeExc, takeMisp, issueFire, cmplHit;

  assign headIdx   = headPtr[IDX_W-1:0];
  assign tailIdx   = tailPtr[IDX_W-1:0];
  assign full      = (headPtr[IDX_W] != tailPtr[IDX_W]) && (headIdx == tailIdx);
  assign headReady = validQ[headIdx] && doneQ[headIdx];
  assign takeExc   = headReady && headExc;
  assign takeMisp  = headReady && !headExc && (headKind == KIND_BRANCH) && headMispred;
  assign flushNow  = takeExc || takeMisp;
  assign commitFire = headReady && !headExc;
  assign issueReady = !full && !flushNow;
  assign issueFire  = issueValid && issueReady;
  assign cmplHit    = cmplValid && validQ[cmplIdx] && !doneQ[cmplIdx] && !flushNow;

  assign stb.issueWe = issueFire;
  assign stb.cmplWe  = cmplHit;

  always_comb begin
    flushCause = CAUSE_NONE;
    if (takeExc)       flushCause = CAUSE_EXC;
    else if (takeMisp) flushCause = CAUSE_MISPRED;
  end

  always_comb begin
    validNext = validQ;
    doneNext  = doneQ;
    if (commitFire) validNext[headIdx] = 1'b0;
    if (issueFire) begin
      validNext[tailIdx] = 1'b1;
      doneNext[tailIdx]  = issueExc;
    end
    if (cmplHit) doneNext[cmplIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flushNow) begin
      validQ  <= '0;
      doneQ   <= '0;
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      validQ  <= validNext;
      doneQ   <= doneNext;
      if (commitFire) headPtr <= headPtr + PTR_W'(1);
      if (issueFire)  tailPtr <= tailPtr + PTR_W'(1);
    end
  end
endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  tailIdx,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [1:0]        issueKind,
  input  logic [REG_W-1:0]  issueDest,
  input  logic              issueExc,
  input  logic [ADDR_W-1:0] issueAddr,
  input  logic [IDX_W-1:0]  cmplIdx,
  input  logic [DATA_W-1:0] cmplValue,
  input  logic              cmplExc,
  input  logic              cmplMispred,
  output logic [1:0]        headKind,
  output logic              headExc,
  output logic              headMispred,
  output logic [REG_W-1:0]  headDest,
  output logic [DATA_W-1:0] headValue,
  output logic [ADDR_W-1:0] headAddr
);
  logic [1:0]        kindArr  [DEPTH];
  logic              excArr   [DEPTH];
  logic              mispArr  [DEPTH];
  logic [REG_W-1:0]  destArr  [DEPTH];
  logic [DATA_W-1:0] valueArr [DEPTH];
  logic [ADDR_W-1:0] addrArr  [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : gSlot
    logic [1:0]        kind;
    logic              exc, misp;
    logic [REG_W-1:0]  dest;
    logic [DATA_W-1:0] value;
    logic [ADDR_W-1:0] addr;
    logic issueHere, cmplHere;

    assign issueHere = stb.issueWe && (tailIdx == IDX_W'(e));
    assign cmplHere  = stb.cmplWe && (cmplIdx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        kind <= KIND_REG; exc <= 1'b0; misp <= 1'b0;
        dest <= '0; value <= '0; addr <= '0;
      end else if (issueHere) begin
        kind <= issueKind; exc <= issueExc; misp <= 1'b0;
        dest <= issueDest; value <= '0; addr <= issueAddr;
      end else if (cmplHere) begin
        value <= cmplValue; exc <= cmplExc; misp <= cmplMispred;
      end
    end

    assign kindArr[e]  = kind;
    assign excArr[e]   = exc;
    assign mispArr[e]  = misp;
    assign destArr[e]  = dest;
    assign valueArr[e] = value;
    assign addrArr[e]  = addr;
  end

  assign headKind    = kindArr[headIdx];
  assign headExc     = excArr[headIdx];
  assign headMispred = mispArr[headIdx];
  assign headDest    = destArr[headIdx];
  assign headValue   = valueArr[headIdx];
  assign headAddr    = addrArr[headIdx];
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [1:0]        issueKind,
  input  logic [REG_W-1:0]  issueDest,
  input  logic              issueExc,
  input  logic [ADDR_W-1:0] issueAddr,
  output logic              issueReady,
  output logic [IDX_W-1:0]  issueIdx,
  input  logic              cmplValid,
  input  logic [IDX_W-1:0]  cmplIdx,
  input  logic [DATA_W-1:0] cmplValue,
  input  logic              cmplExc,
  input  logic              cmplMispred,
  output logic              commitValid,
  output logic [REG_W-1:0]  commitDest,
  output logic [DATA_W-1:0] commitValue,
  output logic [ADDR_W-1:0] commitAddr,
  output logic              commitIsStore,
  output logic              commitRegWrite,
  output logic              flushPulse,
  output logic [1:0]        flushCause
);
  strobe_t          stb;
  logic [IDX_W-1:0] headIdx;
  logic [1:0]       headKind;
  logic             headExc, headMispred;

  rob_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueExc(issueExc),
    .cmplValid(cmplValid), .cmplIdx(cmplIdx),
    .headExc(headExc), .headMispred(headMispred), .headKind(headKind),
    .issueReady(issueReady), .tailIdx(issueIdx), .headIdx(headIdx),
    .stb(stb), .commitFire(commitValid), .flushNow(flushPulse),
    .flushCause(flushCause)
  );

  rob_data #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) data_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .tailIdx(issueIdx), .headIdx(headIdx),
    .issueKind(issueKind), .issueDest(issueDest), .issueExc(issueExc),
    .issueAddr(issueAddr),
    .cmplIdx(cmplIdx), .cmplValue(cmplValue), .cmplExc(cmplExc),
    .cmplMispred(cmplMispred),
    .headKind(headKind), .headExc(headExc), .headMispred(headMispred),
    .headDest(commitDest), .headValue(commitValue), .headAddr(commitAddr)
  );

  assign commitIsStore  = commitValid && (headKind == KIND_STORE);
  assign commitRegWrite = commitValid && (headKind == KIND_REG);
endmodule

// File: rtl/reorder_buffer_checker.sv
module reorder_buffer_checker #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             issueValid,
  input logic             issueReady,
  input logic [IDX_W-1:0] issueIdx,
  input logic             commitValid,
  input logic             commitIsStore,
  input logic             commitRegWrite,
  input logic             flushPulse,
  input logic [1:0]       flushCause
);
  int unsigned occ;

  always_ff @(posedge clk) begin
    if (!rstN || flushPulse) occ <= 0;
    else occ <= occ + ((issueValid && issueReady) ? 1 : 0) - (commitValid ? 1 : 0);
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    occ <= DEPTH);
  assert_stall_when_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!issueReady && !flushPulse) |-> (occ == DEPTH));
  assert_exc_blocks_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flushPulse && flushCause == 2'd1) |-> !commitValid);
  assert_mispred_commits_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flushPulse && flushCause == 2'd2) |-> commitValid);
  assert_cause_only_with_flush_R5: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse == (flushCause != 2'd0));
  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |=> (issueIdx == '0 && issueReady && !commitValid));
  assert_kind_flags_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(commitIsStore && commitRegWrite));
  assert_idx_advance_R9: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady) |=> (issueIdx == IDX_W'($past(issueIdx) + 1'b1)));
  assert_idx_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!(issueValid && issueReady) && !flushPulse) |=> $stable(issueIdx));
endmodule

bind reorder_buffer reorder_buffer_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
  .issueIdx(issueIdx), .commitValid(commitValid), .commitIsStore(commitIsStore),
  .commitRegWrite(commitRegWrite), .flushPulse(flushPulse), .flushCause(flushCause)
);

// File: tb/reorder_buffer_tb_top.sv
module reorder_buffer_tb_top;
  localparam int DEPTH = 8, REG_W = 5, DATA_W = 32, ADDR_W = 32;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rstN = 1'b0;
  always #5 clk = ~clk;

  logic issueValid = 0, issueExc = 0, cmplValid = 0, cmplExc = 0, cmplMispred = 0;
  logic [1:0] issueKind = 0;
  logic [REG_W-1:0] issueDest = 0;
  logic [ADDR_W-1:0] issueAddr = 0;
  logic [IDX_W-1:0] cmplIdx = 0;
  logic [DATA_W-1:0] cmplValue = 0;
  logic issueReady, commitValid, commitIsStore, commitRegWrite, flushPulse;
  logic [IDX_W-1:0] issueIdx;
  logic [REG_W-1:0] commitDest;
  logic [DATA_W-1:0] commitValue;
  logic [ADDR_W-1:0] commitAddr;
  logic [1:0] flushCause;

  reorder_buffer #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueKind(issueKind),
    .issueDest(issueDest), .issueExc(issueExc), .issueAddr(issueAddr),
    .issueReady(issueReady), .issueIdx(issueIdx), .cmplValid(cmplValid),
    .cmplIdx(cmplIdx), .cmplValue(cmplValue), .cmplExc(cmplExc),
    .cmplMispred(cmplMispred), .commitValid(commitValid), .commitDest(commitDest),
    .commitValue(commitValue), .commitAddr(commitAddr), .commitIsStore(commitIsStore),
    .commitRegWrite(commitRegWrite), .flushPulse(flushPulse), .flushCause(flushCause)
  );

  int checks = 0, errors = 0;
  int nCommit = 0, nFlush = 0;

  // bench queue model
  bit mValid[DEPTH], mDone[DEPTH], mExc[DEPTH], mMisp[DEPTH];
  int mKind[DEPTH], mDest[DEPTH];
  longint mValue[DEPTH], mAddr[DEPTH];
  int mHead = 0, mTail = 0, mCount = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void modelReset();
    for (int i = 0; i < DEPTH; i++) begin
      mValid[i] = 0; mDone[i] = 0; mExc[i] = 0; mMisp[i] = 0;
    end
    mHead = 0; mTail = 0; mCount = 0;
  endfunction

  // called at negedge with inputs already driven
  task automatic step();
    bit hv, expCommit, expFlush, expReady, iFire, cHit;
    int expCause;
    hv = (mCount > 0) && mDone[mHead];
    expCommit = hv && !mExc[mHead];
    expCause = 0;
    if (hv && mExc[mHead]) expCause = 1;
    else if (hv && mKind[mHead] == 2 && mMisp[mHead]) expCause = 2;
    expFlush = expCause != 0;
    expReady = (mCount < DEPTH) && !expFlush;
    chk(commitValid == expCommit, "R2", "commitValid", commitValid, expCommit);
    chk(flushPulse == expFlush, "R5", "flushPulse", flushPulse, expFlush);
    chk(flushCause == expCause, "R6", "flushCause", flushCause, expCause);
    chk(issueReady == expReady, "R7", "issueReady", issueReady, expReady);
    chk(issueIdx == mTail, "R9", "issueIdx", issueIdx, mTail);
    if (expCommit && commitValid) begin
      chk(commitDest == mDest[mHead], "R3", "commitDest", commitDest, mDest[mHead]);
      chk(commitValue == mValue[mHead], "R3", "commitValue", commitValue, mValue[mHead]);
      chk(commitRegWrite == (mKind[mHead] == 0), "R3", "commitRegWrite", commitRegWrite, mKind[mHead] == 0);
      chk(commitIsStore == (mKind[mHead] == 1), "R4", "commitIsStore", commitIsStore, mKind[mHead] == 1);
      if (mKind[mHead] == 1)
        chk(commitAddr == mAddr[mHead], "R4", "commitAddr", commitAddr, mAddr[mHead]);
    end
    if (commitValid) nCommit++;
    if (flushPulse) nFlush++;
    iFire = issueValid && expReady;
    cHit = cmplValid && mValid[cmplIdx] && !mDone[cmplIdx] && !expFlush;
    @(posedge clk);
    if (expFlush) modelReset();
    else begin
      if (expCommit) begin
        mValid[mHead] = 0; mHead = (mHead + 1) % DEPTH; mCount--;
      end
      if (iFire) begin
        mValid[mTail] = 1; mDone[mTail] = issueExc; mExc[mTail] = issueExc;
        mMisp[mTail] = 0; mKind[mTail] = issueKind; mDest[mTail] = issueDest;
        mAddr[mTail] = issueAddr; mValue[mTail] = 0;
        mTail = (mTail + 1) % DEPTH; mCount++;
      end
      if (cHit) begin
        mDone[cmplIdx] = 1; mExc[cmplIdx] = cmplExc; mMisp[cmplIdx] = cmplMispred;
        mValue[cmplIdx] = cmplValue;
      end
    end
    @(negedge clk);
    issueValid = 0; issueExc = 0; cmplValid = 0; cmplExc = 0; cmplMispred = 0;
  endtask

  task automatic doIssue(int kind, int dest, bit exc, longint addr, output int idx);
    idx = mTail;
    issueValid = 1; issueKind = kind[1:0]; issueDest = dest[REG_W-1:0];
    issueExc = exc; issueAddr = addr[ADDR_W-1:0];
    step();
  endtask

  task automatic doCmpl(int idx, longint val, bit exc, bit misp);
    cmplValid = 1; cmplIdx = idx[IDX_W-1:0]; cmplValue = val[DATA_W-1:0];
    cmplExc = exc; cmplMispred = misp;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a, b, c, d, base;
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk(issueReady == 1, "R1", "issueReady", issueReady, 1);
    chk(commitValid == 0, "R1", "commitValid", commitValid, 0);
    chk(flushPulse == 0 && flushCause == 0, "R1", "flush", flushPulse, 0);
    chk(issueIdx == 0, "R1", "issueIdx", issueIdx, 0);

    // R8 stray completion to empty slot 3, then R2 reverse-order completion
    doCmpl(3, 64'hDEAD, 0, 0);
    doIssue(0, 1, 0, 0, a); doIssue(0, 2, 0, 0, b); doIssue(0, 3, 0, 0, c); doIssue(0, 4, 0, 0, d);
    base = nCommit;
    doCmpl(c, 64'h33, 0, 0); doCmpl(b, 64'h22, 0, 0);
    idle(2);
    chk(nCommit == base, "R2", "commits before oldest done", nCommit - base, 0);
    doCmpl(a, 64'h11, 0, 0);
    idle(6);
    chk(nCommit - base == 3, "R8", "commits with slot 3 pending", nCommit - base, 3);
    doCmpl(d, 64'h44, 0, 0);
    idle(2);
    chk(nCommit - base == 4, "R2", "all four retired", nCommit - base, 4);

    // R4 store waits for data
    doIssue(1, 0, 0, 64'h100, a);
    base = nCommit;
    idle(3);
    chk(nCommit == base, "R4", "store before data", nCommit - base, 0);
    doCmpl(a, 64'hBEEF, 0, 0);
    idle(2);
    chk(nCommit - base == 1, "R4", "store retired", nCommit - base, 1);

    // R5 deferred exception on a younger entry
    doIssue(0, 5, 0, 0, a); doIssue(0, 6, 0, 0, b); doIssue(0, 7, 0, 0, c);
    base = nCommit;
    doCmpl(b, 64'h66, 1, 0); doCmpl(c, 64'h77, 0, 0);
    idle(2);
    chk(nFlush == 0, "R5", "no early flush", nFlush, 0);
    doCmpl(a, 64'h55, 0, 0);
    idle(4);
    chk(nFlush == 1, "R5", "one flush", nFlush, 1);
    chk(nCommit - base == 1, "R5", "only older retired", nCommit - base, 1);

    // R10 exception at issue
    doIssue(0, 8, 1, 0, a);
    idle(2);
    chk(nFlush == 2, "R10", "issue fault flush", nFlush, 2);

    // R6 mispredicted branch
    doIssue(2, 0, 0, 0, a); doIssue(0, 9, 0, 0, b);
    base = nCommit;
    doCmpl(b, 64'h99, 0, 0); doCmpl(a, 64'h4000, 0, 1);
    idle(3);
    chk(nFlush == 3, "R6", "mispredict flush", nFlush, 3);
    chk(nCommit - base == 1, "R6", "branch only retired", nCommit - base, 1);

    // R7 fill beyond capacity
    for (int i = 0; i < DEPTH + 3; i++) doIssue(0, i, 0, 0, a);
    chk(mCount == DEPTH && issueReady == 0, "R7", "full stall", issueReady, 0);
    for (int i = 0; i < DEPTH; i++) doCmpl(i, 64'h1000 + i, 0, 0);
    idle(DEPTH + 1);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      issueValid = ($urandom_range(0, 9) < 6);
      issueKind = 2'($urandom_range(0, 2));
      issueDest = REG_W'($urandom);
      issueExc = ($urandom_range(0, 39) == 0);
      issueAddr = $urandom;
      cmplValid = ($urandom_range(0, 9) < 6);
      cmplIdx = IDX_W'($urandom);
      cmplValue = $urandom;
      cmplExc = ($urandom_range(0, 29) == 0);
      cmplMispred = ($urandom_range(0, 6) == 0);
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule